// File: doc/BRIEF.md
# Thread-Block Residency Admission Unit

This unit decides whether a thread-block may become resident on a multiprocessor. A request carries the thread count of the block, the registers used by each thread and the shared-memory bytes the block needs. The unit turns the thread count into a whole number of warps and works out the register charge. It then tests four resources against what is still free: warp slots, register file, shared memory and block slots. A block is admitted only when every one of the four fits. The scarcest resource therefore sets the limit.

On acceptance the unit reserves all four resources and returns a slot tag. The block keeps its resources until a done pulse arrives with that tag. The unit continuously reports the number of resident warps. It also reports occupancy, which is the fraction of the warp capacity in use, with 8 fractional bits. A scheduler upstream presents one request at a time and reads the answer one cycle later.

Top module: `resid_admit`

## Requirements
- R1: A request with a thread count of 0 or above MAX_THREADS (1024) is rejected. A rejected request changes no resource count.
- R2: A block occupies ceil(threads/32) warps. On acceptance, `active_warps` rises by exactly that amount at the same edge that produces the response.
- R3: The register charge is registers-per-thread × 32 × warps, so a partly filled last warp is charged in full. A block is rejected when its charge exceeds the registers still free (REG_CAP minus the charges of resident blocks).
- R4: A block is rejected when its shared-memory bytes exceed SMEM_CAP minus the bytes held by resident blocks.
- R5: A block is rejected when its warps exceed MAX_WARPS minus `active_warps`. `active_warps` never exceeds MAX_WARPS.
- R6: A block is rejected when all SLOTS block slots are occupied. On acceptance, `rsp_tag` is the lowest-numbered free slot.
- R7: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and is low otherwise. `rsp_accept` is 1 for admit and 0 for reject.
- R8: A `done_valid` pulse whose `done_tag` names an occupied slot frees that block's warps, registers, shared memory and slot at that edge. A pulse that names a free slot has no effect.
- R9: `occupancy` equals floor(active_warps × 256 / MAX_WARPS) as a 9-bit value, so a full unit reads 256.
- R10: When a request and a release happen in the same cycle, the request is judged against the resources held before the release. The slot being freed cannot be granted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Admission request present |
| req_threads | input | THR_W | Threads in the block |
| req_regs | input | RPT_W | Registers per thread |
| req_smem | input | SC_W | Shared-memory bytes for the block |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_accept | output | 1 | 1 = admitted, 0 = rejected |
| rsp_tag | output | TAG_W | Slot granted to an admitted block |
| done_valid | input | 1 | Block-completion pulse |
| done_tag | input | TAG_W | Slot of the completing block |
| active_warps | output | AW_W | Resident warp count |
| occupancy | output | 9 | Active warps / MAX_WARPS, 8 fractional bits |

## Verification
The assertions assume that requests arrive one per cycle, with no handshake. They also assume that a done pulse names only tags the unit has handed out, although a pulse naming a free slot must still be harmless. The stimulus keeps the done tag inside the slot range. It deliberately repeats done pulses on freed slots, and it sends requests whose thread count is zero or too large. A small configuration (16 warps, 4 slots) lets the sweeps reach every resource boundary exactly. The sweeps are followed by a long pseudo-random mix that a bench model replays.

// File: rtl/resid_pkg.sv
package resid_pkg;

  // Warps taken by a block of thr threads at warp width ww (rounded up).
  function automatic int unsigned warp_count(input int unsigned thr, input int unsigned ww);
    return (thr + ww - 1) / ww;
  endfunction

  // Registers charged to a block: every warp is charged as a full warp.
  function automatic int unsigned reg_charge(input int unsigned rpt, input int unsigned warps,
                                             input int unsigned ww);
    return rpt * ww * warps;
  endfunction

  // Occupancy with 8 fractional bits.
  function automatic int unsigned occ_frac(input int unsigned act, input int unsigned cap);
    return (act * 256) / cap;
  endfunction

endpackage

// File: rtl/resid_demand.sv
module resid_demand #(
  parameter int unsigned WARP_W      = 32,
  parameter int unsigned MAX_THREADS = 1024,
  parameter int unsigned THR_W       = 11,
  parameter int unsigned RPT_W       = 8,
  parameter int unsigned BW_W        = 6,
  parameter int unsigned DR_W        = 19
) (
  input  logic [THR_W-1:0] threads,
  input  logic [RPT_W-1:0] rpt,
  output logic             size_ok,
  output logic [BW_W-1:0]  warps,
  output logic [DR_W-1:0]  regs
);
  int unsigned w_int;

  always_comb begin
    size_ok = (threads != '0) && (int'(threads) <= int'(MAX_THREADS));
    w_int   = resid_pkg::warp_count(int'(threads), WARP_W);
    warps   = BW_W'(w_int);
    regs    = DR_W'(resid_pkg::reg_charge(int'(rpt), w_int, WARP_W));
  end
endmodule

// File: rtl/resid_pool.sv
module resid_pool #(
  parameter int unsigned CAP = 64,
  parameter int unsigned W   = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] need,
  input  logic         take,
  input  logic         give,
  input  logic [W-1:0] give_amt,
  output logic [W-1:0] used,
  output logic         fits
);
  logic [W:0] sum_chk;
  logic [W:0] nxt;

  always_comb begin
    sum_chk = {1'b0, used} + {1'b0, need};
    fits    = sum_chk <= (W+1)'(CAP);
    nxt     = {1'b0, used};
    if (take) nxt = nxt + {1'b0, need};
    if (give) nxt = nxt - {1'b0, give_amt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used <= '0;
    else        used <= nxt[W-1:0];
  end
endmodule

// File: rtl/resid_slot_tab.sv
module resid_slot_tab #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned TAG_W = 5,
  parameter int unsigned BW_W  = 6,
  parameter int unsigned DR_W  = 19,
  parameter int unsigned SC_W  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [BW_W-1:0]  alloc_w,
  input  logic [DR_W-1:0]  alloc_r,
  input  logic [SC_W-1:0]  alloc_s,
  input  logic             done_valid,
  input  logic [TAG_W-1:0] done_tag,
  output logic             any_free,
  output logic [TAG_W-1:0] free_tag,
  output logic             rel_fire,
  output logic [BW_W-1:0]  rel_w,
  output logic [DR_W-1:0]  rel_r,
  output logic [SC_W-1:0]  rel_s
);
  logic [SLOTS-1:0] occ;
  logic [BW_W-1:0]  st_w [SLOTS];
  logic [DR_W-1:0]  st_r [SLOTS];
  logic [SC_W-1:0]  st_s [SLOTS];

  // Lowest-numbered free slot wins.
  always_comb begin
    any_free = 1'b0;
    free_tag = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        any_free = 1'b1;
        free_tag = TAG_W'(i);
      end
    end
  end

  // Release only a slot that is actually held.
  always_comb begin
    rel_fire = 1'b0;
    rel_w    = '0;
    rel_r    = '0;
    rel_s    = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (done_valid && done_tag == TAG_W'(i) && occ[i]) begin
        rel_fire = 1'b1;
        rel_w    = st_w[i];
        rel_r    = st_r[i];
        rel_s    = st_s[i];
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ[g]  <= 1'b0;
        st_w[g] <= '0;
        st_r[g] <= '0;
        st_s[g] <= '0;
      end else if (alloc && free_tag == TAG_W'(g)) begin
        occ[g]  <= 1'b1;
        st_w[g] <= alloc_w;
        st_r[g] <= alloc_r;
        st_s[g] <= alloc_s;
      end else if (rel_fire && done_tag == TAG_W'(g)) begin
        occ[g]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/resid_admit.sv
module resid_admit #(
  parameter int unsigned WARP_W      = 32,
  parameter int unsigned MAX_THREADS = 1024,
  parameter int unsigned MAX_WARPS   = 64,
  parameter int unsigned REG_CAP     = 65536,
  parameter int unsigned SMEM_CAP    = 65536,
  parameter int unsigned SLOTS       = 32,
  parameter int unsigned RPT_W       = 8,
  parameter int unsigned THR_W       = 11,
  localparam int unsigned TAG_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned AW_W  = $clog2(MAX_WARPS + 1),
  localparam int unsigned SC_W  = $clog2(SMEM_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [THR_W-1:0] req_threads,
  input  logic [RPT_W-1:0] req_regs,
  input  logic [SC_W-1:0]  req_smem,
  output logic             rsp_valid,
  output logic             rsp_accept,
  output logic [TAG_W-1:0] rsp_tag,
  input  logic             done_valid,
  input  logic [TAG_W-1:0] done_tag,
  output logic [AW_W-1:0]  active_warps,
  output logic [8:0]       occupancy
);
  localparam int unsigned BW_W = $clog2(MAX_THREADS / WARP_W + 1);
  localparam int unsigned RC_W = $clog2(REG_CAP + 1);
  localparam int unsigned DR_W = RPT_W + $clog2(WARP_W) + BW_W;
  localparam int unsigned PW_W = (AW_W > BW_W) ? AW_W : BW_W;
  localparam int unsigned PR_W = (RC_W > DR_W) ? RC_W : DR_W;

  // Named internal events, also seen by the checker.
  logic             size_ok;
  logic [BW_W-1:0]  dem_w;
  logic [DR_W-1:0]  dem_r;
  logic             fit_w, fit_r, fit_s;
  logic             any_free;
  logic [TAG_W-1:0] free_tag;
  logic             adm_ok;
  logic             rel_fire;
  logic [BW_W-1:0]  rel_w;
  logic [DR_W-1:0]  rel_r;
  logic [SC_W-1:0]  rel_s;
  logic [PW_W-1:0]  warp_used;
  logic [PR_W-1:0]  reg_used;
  logic [SC_W-1:0]  smem_used;

  resid_demand #(
    .WARP_W(WARP_W), .MAX_THREADS(MAX_THREADS), .THR_W(THR_W),
    .RPT_W(RPT_W), .BW_W(BW_W), .DR_W(DR_W)
  ) u_dem (
    .threads(req_threads), .rpt(req_regs),
    .size_ok(size_ok), .warps(dem_w), .regs(dem_r)
  );

  assign adm_ok = req_valid && size_ok && fit_w && fit_r && fit_s && any_free;

  resid_pool #(.CAP(MAX_WARPS), .W(PW_W)) u_pool_warp (
    .clk(clk), .rst_n(rst_n), .need(PW_W'(dem_w)), .take(adm_ok),
    .give(rel_fire), .give_amt(PW_W'(rel_w)), .used(warp_used), .fits(fit_w)
  );

  resid_pool #(.CAP(REG_CAP), .W(PR_W)) u_pool_reg (
    .clk(clk), .rst_n(rst_n), .need(PR_W'(dem_r)), .take(adm_ok),
    .give(rel_fire), .give_amt(PR_W'(rel_r)), .used(reg_used), .fits(fit_r)
  );

  resid_pool #(.CAP(SMEM_CAP), .W(SC_W)) u_pool_smem (
    .clk(clk), .rst_n(rst_n), .need(req_smem), .take(adm_ok),
    .give(rel_fire), .give_amt(rel_s), .used(smem_used), .fits(fit_s)
  );

  resid_slot_tab #(
    .SLOTS(SLOTS), .TAG_W(TAG_W), .BW_W(BW_W), .DR_W(DR_W), .SC_W(SC_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc(adm_ok),
    .alloc_w(dem_w), .alloc_r(dem_r), .alloc_s(req_smem),
    .done_valid(done_valid), .done_tag(done_tag),
    .any_free(any_free), .free_tag(free_tag),
    .rel_fire(rel_fire), .rel_w(rel_w), .rel_r(rel_r), .rel_s(rel_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_tag    <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_accept <= adm_ok;
      rsp_tag    <= adm_ok ? free_tag : '0;
    end
  end

  always_comb begin
    active_warps = AW_W'(warp_used);
    occupancy    = 9'(resid_pkg::occ_frac(int'(warp_used), MAX_WARPS));
  end
endmodule

// File: rtl/resid_admit_chk.sv
module resid_admit_chk #(
  parameter int unsigned THR_W       = 11,
  parameter int unsigned AW_W        = 7,
  parameter int unsigned MAX_THREADS = 1024,
  parameter int unsigned MAX_WARPS   = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [THR_W-1:0] req_threads,
  input logic             rsp_valid,
  input logic             rsp_accept,
  input logic [AW_W-1:0]  active_warps,
  input logic [8:0]       occupancy,
  input logic             adm_ok,
  input logic             rel_fire
);
  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_bad_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_threads == '0 || int'(req_threads) > int'(MAX_THREADS))) |=> !rsp_accept);

  assert_warp_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_warps) <= int'(MAX_WARPS));

  assert_reject_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !adm_ok && !rel_fire) |=> $stable(active_warps));

  assert_accept_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adm_ok && !rel_fire) |=> active_warps > $past(active_warps));

  assert_release_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_fire && !adm_ok) |=> active_warps < $past(active_warps));

  assert_occ_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_warps == '0) |-> (occupancy == 9'd0));

  assert_occ_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(active_warps) == int'(MAX_WARPS)) |-> (occupancy == 9'd256));
endmodule

bind resid_admit resid_admit_chk #(
  .THR_W(THR_W), .AW_W(AW_W), .MAX_THREADS(MAX_THREADS), .MAX_WARPS(MAX_WARPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
  .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .active_warps(active_warps),
  .occupancy(occupancy), .adm_ok(adm_ok), .rel_fire(rel_fire)
);

// File: tb/resid_admit_tb.sv
module resid_admit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [10:0] req_threads = '0;
  logic [7:0]  req_regs = '0;
  logic [12:0] req_smem = '0;
  logic        rsp_valid, rsp_accept;
  logic [1:0]  rsp_tag;
  logic        done_valid = 1'b0;
  logic [1:0]  done_tag = '0;
  logic [4:0]  active_warps;
  logic [8:0]  occupancy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model of resident blocks.
  bit occ_m [4];
  int w_m [4];
  int r_m [4];
  int s_m [4];

  always #5 clk = ~clk;

  resid_admit #(
    .WARP_W(32), .MAX_THREADS(1024), .MAX_WARPS(16), .REG_CAP(8192),
    .SMEM_CAP(4096), .SLOTS(4), .RPT_W(8), .THR_W(11)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
    .req_regs(req_regs), .req_smem(req_smem), .rsp_valid(rsp_valid),
    .rsp_accept(rsp_accept), .rsp_tag(rsp_tag), .done_valid(done_valid),
    .done_tag(done_tag), .active_warps(active_warps), .occupancy(occupancy)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, check at the next falling edge.
  task automatic step(input bit rv, input int thr, input int rg, input int sm,
                      input bit dv, input int dt, input string rq);
    int w, r, wu, ru, su, ftag;
    bit ok;
    req_valid   = rv;
    req_threads = 11'(thr);
    req_regs    = 8'(rg);
    req_smem    = 13'(sm);
    done_valid  = dv;
    done_tag    = 2'(dt);
    w = (thr + 31) / 32;
    r = rg * 32 * w;
    wu = 0; ru = 0; su = 0; ftag = -1;
    for (int i = 3; i >= 0; i--) begin
      if (occ_m[i]) begin
        wu += w_m[i]; ru += r_m[i]; su += s_m[i];
      end else begin
        ftag = i;
      end
    end
    ok = rv && thr >= 1 && thr <= 1024 && (wu + w) <= 16 && (ru + r) <= 8192 &&
         (su + sm) <= 4096 && ftag >= 0;
    @(negedge clk);
    chk("R7", "rsp_valid", int'(rsp_valid), int'(rv));
    if (rv) chk(rq, "rsp_accept", int'(rsp_accept), int'(ok));
    if (ok) chk("R6", "rsp_tag", int'(rsp_tag), ftag);
    if (dv && occ_m[dt]) occ_m[dt] = 1'b0;
    if (ok) begin
      occ_m[ftag] = 1'b1; w_m[ftag] = w; r_m[ftag] = r; s_m[ftag] = sm;
    end
    wu = 0;
    for (int i = 0; i < 4; i++) if (occ_m[i]) wu += w_m[i];
    chk(rq, "active_warps", int'(active_warps), wu);
    chk("R9", "occupancy", int'(occupancy), (wu * 256) / 16);
    req_valid  = 1'b0;
    done_valid = 1'b0;
  endtask

  task automatic release_all(input string rq);
    for (int i = 0; i < 4; i++) if (occ_m[i]) step(0, 0, 0, 0, 1, i, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      occ_m[i] = 1'b0; w_m[i] = 0; r_m[i] = 0; s_m[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "reset rsp_valid", int'(rsp_valid), 0);
    chk("R2", "reset active_warps", int'(active_warps), 0);
    chk("R9", "reset occupancy", int'(occupancy), 0);

    // R1 R2 R5: thread-count sweep from an empty unit.
    for (int t = 0; t <= 1100; t++) begin
      step(1, t, 1, 0, 0, 0, (t == 0 || t > 1024) ? "R1" : (t > 512 ? "R5" : "R2"));
      release_all("R8");
    end

    // R3: register sweep with 8-warp blocks; boundary at 32 regs per thread.
    for (int g = 0; g < 64; g++) begin
      step(1, 256, g, 0, 0, 0, "R3");
      release_all("R8");
    end
    // R3: partial last warp charged in full (33 threads = 2 warps).
    step(1, 33, 128, 0, 0, 0, "R3");
    release_all("R8");
    step(1, 33, 129, 0, 0, 0, "R3");
    release_all("R8");

    // R4: shared-memory sweep across the capacity edge.
    for (int s = 0; s <= 4200; s += 3) begin
      step(1, 32, 1, s, 0, 0, "R4");
      release_all("R8");
    end
    step(1, 32, 1, 4096, 0, 0, "R4");
    step(1, 32, 1, 1, 0, 0, "R4");
    release_all("R8");

    // R6: fill every slot, then one more; lowest free slot is reused.
    for (int k = 0; k < 5; k++) step(1, 32, 1, 10, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 1, "R8");
    step(1, 64, 2, 20, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 2, "R8");
    step(0, 0, 0, 0, 1, 2, "R8");
    step(1, 32, 1, 0, 0, 0, "R6");

    // R10: request and release together while every slot is full.
    step(1, 32, 1, 0, 1, 3, "R10");
    step(1, 32, 1, 0, 0, 0, "R10");
    release_all("R8");
    // R10: warp pool full; the release does not help the same-cycle request.
    step(1, 256, 0, 0, 0, 0, "R5");
    step(1, 256, 0, 0, 0, 0, "R5");
    step(1, 32, 0, 0, 1, 0, "R10");
    step(1, 32, 0, 0, 0, 0, "R10");
    release_all("R8");

    // Mixed traffic replayed against the bench model.
    for (int n = 0; n < 3000; n++) begin
      int thr, rg, sm, dt;
      bit rv, dv;
      rv  = ($urandom % 4) != 0;
      thr = $urandom % 600;
      rg  = $urandom % 40;
      sm  = $urandom % 2000;
      dv  = ($urandom % 3) == 0;
      dt  = $urandom % 4;
      step(rv, thr, rg, sm, dv, dt, "R2");
    end
    release_all("R8");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule